// File: doc/BRIEF.md
# Receive Frame Buffer with Streaming Read Port

This block holds received frame words between a receive datapath and the application that consumes them. Each word is written with start-of-frame and end-of-frame markers and an error vector. The word is stored together with these markers in a single memory entry. On the read side the words are presented on a valid/ready streaming port. The port carries packet start and end markers, and the error vector appears on the closing word of each frame. Both sides run on one clock.

Two release policies are available. In cut-through mode (`sf_mode` = 0), any stored word can be read at once, and `data_avail` announces that unread data is present, even part of a frame. In store-and-forward mode (`sf_mode` = 1), nothing is offered until at least one complete frame sits in the buffer, and `data_avail` stays low.

Occupancy is compared against two thresholds supplied at the ports. These comparisons produce the almost-full and almost-empty flags. A word that arrives while the buffer is full is discarded, and the frame it belonged to is flagged on its closing word.

Top module: `rx_pkt_fifo`

## Requirements
- R1: After reset the buffer is empty: `rd_valid` = 0, `data_avail` = 0, `almost_full` = 0, and `almost_empty` = 1 whenever `aempty_lvl` > 0.
- R2: Words leave in write order. `rd_sop` is 1 exactly on the first word of a frame and `rd_eop` is 1 exactly on its last word.
- R3: The read side moves on only at a rising clock edge where both `rd_valid` and `rd_ready` are 1. While `rd_ready` is 0, the offered word and its markers are held unchanged.
- R4: `rd_err` carries the error vector written with the frame's closing word and is presented on the beat where `rd_eop` = 1. On every other beat it is zero.
- R5: In cut-through mode, `data_avail` is 1 whenever at least one unread word is stored, including when no end-of-frame word has arrived yet.
- R6: In store-and-forward mode, `data_avail` is always 0, and `rd_valid` stays 0 until a word marked end-of-frame has been written.
- R7: `almost_full` is 1 exactly when the stored word count is greater than or equal to `afull_lvl`.
- R8: `almost_empty` is 1 exactly when the stored word count is less than `aempty_lvl`.
- R9: A write while 16 words (the default depth) are stored is dropped. The next accepted end-of-frame word carries bit 5 of its error vector set (mask 6'h20), OR'ed with the written error bits.
- R10: In cut-through mode, `rd_valid` is 1 whenever at least one word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_mode | input | 1 | 1 selects store-and-forward, 0 selects cut-through |
| afull_lvl | input | AW+1 | Almost-full threshold in words |
| aempty_lvl | input | AW+1 | Almost-empty threshold in words |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write data word |
| wr_sop | input | 1 | Word starts a frame |
| wr_eop | input | 1 | Word ends a frame |
| wr_err | input | EW | Error vector, meaningful with `wr_eop` |
| rd_ready | input | 1 | Application accepts the offered word |
| rd_valid | output | 1 | A word is offered |
| rd_data | output | DW | Offered data word |
| rd_sop | output | 1 | Offered word starts a frame |
| rd_eop | output | 1 | Offered word ends a frame |
| rd_err | output | EW | Frame error vector, nonzero only with `rd_eop` |
| data_avail | output | 1 | Unread data present (cut-through only) |
| almost_full | output | 1 | Occupancy at or above `afull_lvl` |
| almost_empty | output | 1 | Occupancy below `aempty_lvl` |

## Verification
Back-pressure is tested by holding `rd_ready` low while a word is offered. A design that advanced regardless would lose words and break the ordering check. The thresholds are probed one word either side of each level, which exposes any off-by-one between `>=` and `>`. Store-and-forward is tested with a partial frame stored: a design that ignored the mode would raise `rd_valid` or `data_avail` early. The buffer is also overfilled and then drained. A design that overwrote stored words, or that forgot to flag the frame, would show wrong data or a closing error vector without bit 5.

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo #(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int EW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sf_mode,
  input  logic [AW:0]   afull_lvl,
  input  logic [AW:0]   aempty_lvl,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_sop,
  input  logic          wr_eop,
  input  logic [EW-1:0] wr_err,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_sop,
  output logic          rd_eop,
  output logic [EW-1:0] rd_err,
  output logic          data_avail,
  output logic          almost_full,
  output logic          almost_empty
);
  localparam int DEPTH = 1 << AW;
  localparam int W     = DW + EW + 2;
  localparam logic [EW-1:0] OVF_BIT = EW'(1) << (EW - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt, frames;
  logic          ovf;

  wire full = (cnt == (AW+1)'(DEPTH));
  wire push = wr_en && !full;
  wire drop = wr_en && full;
  wire pop  = rd_valid && rd_ready;
  wire [W-1:0] head = mem[rp];
  wire [EW-1:0] err_in = wr_err | ((wr_eop && ovf) ? OVF_BIT : '0);

  assign rd_data      = head[DW-1:0];
  assign rd_sop       = head[W-1];
  assign rd_eop       = head[W-2];
  assign rd_err       = rd_eop ? head[DW+EW-1:DW] : '0;
  assign rd_valid     = (cnt != 0) && (!sf_mode || frames != 0);
  assign data_avail   = !sf_mode && (cnt != 0);
  assign almost_full  = cnt >= afull_lvl;
  assign almost_empty = cnt < aempty_lvl;

  always_ff @(posedge clk)
    if (push) mem[wp] <= {wr_sop, wr_eop, err_in, wr_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      frames <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt    <= cnt + (AW+1)'(push) - (AW+1)'(pop);
      frames <= frames + (AW+1)'(push && wr_eop) - (AW+1)'(pop && rd_eop);
      if (drop)                ovf <= 1'b1;
      else if (push && wr_eop) ovf <= 1'b0;
    end
  end

  p_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  p_drop_keeps_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !pop |=> full);
  p_sf_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sf_mode |-> !data_avail);
  p_frames_fit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frames <= cnt);
  p_err_on_eop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err != '0 |-> rd_eop);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !sf_mode |=> rd_valid && $stable(rd_data) && $stable(rd_sop));
endmodule

// File: tb/rx_pkt_fifo_tb.sv
module rx_pkt_fifo_tb;
  localparam int DW = 32, AW = 4, EW = 6;
  logic clk = 0, rst_n = 0, sf_mode = 0;
  logic [AW:0] afull_lvl = 5'd12, aempty_lvl = 5'd2;
  logic wr_en = 0, wr_sop = 0, wr_eop = 0, rd_ready = 0;
  logic [DW-1:0] wr_data = 0;
  logic [EW-1:0] wr_err = 0;
  logic rd_valid, rd_sop, rd_eop, data_avail, almost_full, almost_empty;
  logic [DW-1:0] rd_data;
  logic [EW-1:0] rd_err;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  rx_pkt_fifo #(.DW(DW), .AW(AW), .EW(EW)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] d, input logic s, input logic e, input logic [EW-1:0] er);
    @(negedge clk);
    wr_en = 1; wr_data = d; wr_sop = s; wr_eop = e; wr_err = er;
    @(posedge clk); #1;
    wr_en = 0; wr_sop = 0; wr_eop = 0; wr_err = 0;
  endtask

  task automatic pop(input string req, input logic [DW-1:0] d, input logic s, input logic e, input logic [EW-1:0] er);
    @(negedge clk);
    chk(rd_valid, {req, " valid"}, rd_valid, 1);
    chk(rd_data == d, {req, " data"}, rd_data, d);
    chk(rd_sop == s && rd_eop == e, {req, " sop/eop"}, {rd_sop, rd_eop}, {s, e});
    chk(rd_err == er, "R4 err", rd_err, er);
    rd_ready = 1;
    @(posedge clk); #1;
    rd_ready = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!rd_valid && !data_avail, "R1 empty", {rd_valid, data_avail}, 0);
    chk(almost_empty && !almost_full, "R1 flags", {almost_empty, almost_full}, 2'b10);
  endtask

  task automatic t_cut_through();
    sf_mode = 0;
    push(32'hA0, 1, 0, 0);
    push(32'hA1, 0, 0, 0);
    @(negedge clk);
    chk(data_avail, "R5 partial frame avail", data_avail, 1);
    chk(rd_valid, "R10 valid on partial", rd_valid, 1);
    repeat (3) @(negedge clk);
    chk(rd_valid && rd_data == 32'hA0 && rd_sop, "R3 hold without ready", rd_data, 32'hA0);
    push(32'hA2, 0, 1, 6'h03);
    pop("R2", 32'hA0, 1, 0, 0);
    pop("R2", 32'hA1, 0, 0, 0);
    pop("R4", 32'hA2, 0, 1, 6'h03);
    @(negedge clk);
    chk(!rd_valid && !data_avail, "R3 drained", rd_valid, 0);
  endtask

  task automatic t_store_forward();
    sf_mode = 1;
    push(32'hB0, 1, 0, 0);
    push(32'hB1, 0, 0, 0);
    @(negedge clk);
    chk(!rd_valid, "R6 withheld partial", rd_valid, 0);
    chk(!data_avail, "R6 avail low", data_avail, 0);
    push(32'hB2, 0, 1, 6'h01);
    @(negedge clk);
    chk(rd_valid, "R6 released complete", rd_valid, 1);
    chk(!data_avail, "R6 avail low full frame", data_avail, 0);
    pop("R6", 32'hB0, 1, 0, 0);
    pop("R6", 32'hB1, 0, 0, 0);
    pop("R6", 32'hB2, 0, 1, 6'h01);
    @(negedge clk);
    chk(!rd_valid, "R6 empty after frame", rd_valid, 0);
    sf_mode = 0;
  endtask

  task automatic t_thresholds();
    afull_lvl = 5'd12; aempty_lvl = 5'd3;
    for (int i = 0; i < 12; i++) begin
      push(32'hC0 + i, i == 0, i == 11, 0);
      @(negedge clk);
      if (i == 1)  chk(almost_empty, "R8 below level", almost_empty, 1);
      if (i == 2)  chk(!almost_empty, "R8 at level", almost_empty, 0);
      if (i == 10) chk(!almost_full, "R7 below level", almost_full, 0);
      if (i == 11) chk(almost_full, "R7 at level", almost_full, 1);
    end
    for (int i = 0; i < 12; i++)
      pop("R2", 32'hC0 + i, i == 0, i == 11, 0);
    @(negedge clk);
    chk(almost_empty && !almost_full, "R8 empty again", {almost_empty, almost_full}, 2'b10);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 16; i++) push(32'hD0 + i, i == 0, 0, 0);
    for (int i = 0; i < 3; i++) push(32'hEE, 0, 0, 0);
    pop("R9", 32'hD0, 1, 0, 0);
    push(32'hDF0, 0, 1, 6'h02);
    for (int i = 1; i < 16; i++) pop("R9 kept", 32'hD0 + i, 0, 0, 0);
    pop("R9 flag", 32'hDF0, 0, 1, 6'h22);
    @(negedge clk);
    chk(!rd_valid, "R9 no dropped words", rd_valid, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_cut_through();
        t_store_forward();
        t_thresholds();
        t_overflow();
      end
      begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule